// File: doc/BRIEF.md
# ECC Status Erased-Page Checker

After a flash page has been read through a hardware ECC engine, this block decides what the software-visible outcome of that read should be. It takes the engine's one-byte status word with a start strobe. If the engine reports a correctable result, the block returns the reported corrected-bit count at once and does not look at the data. If the engine reports an uncorrectable result, the block does not trust that verdict straight away. A freshly erased page reads as all ones, and an erased page that has picked up a few bit flips fails the ECC check even though nothing was ever written to it.

In that case the block takes the 2048-byte ECC step as a stream of 512 words of 32 bits, over a valid/ready handshake, and counts the zero bits in them. Counting stops after the first word that pushes the running total above the engine's reported error count. Any words still to come are accepted and thrown away. The page is declared failed only when the zero count is above both the reported error count and half of the ECC strength (24, so half is 12). In every other case the page is classed as erased: the block reports zero corrected bits and asks the caller to overwrite the buffer with 0xFF bytes.

Each decision ends with a single-cycle done pulse. The result code, the count and the fill request are presented alongside that pulse and are held until the next one.

Top module: `ecc_erased_check`

## Requirements
- R1: While reset is asserted and after it is released, done_o, word_ready_o, result_o, count_o and fill_ones_o are all 0.
- R2: A start_i pulse in idle with status bit 7 clear produces done_o in the next cycle. It carries result_o = 0 (correctable), count_o equal to status bits 5:0 and fill_ones_o = 0. Status bit 6 is ignored, and word_ready_o stays 0.
- R3: A start_i pulse in idle with status bit 7 set raises word_ready_o from the next cycle on. The block accepts exactly 512 words, and done_o rises in the cycle after the 512th accepted word, with word_ready_o low in that cycle.
- R4: Each accepted word adds to the running total the number of bits in the word that are 0.
- R5: Once the running total exceeds the reported error count (status bits 5:0), the total freezes at that value. Later words are still accepted but add nothing.
- R6: The result is failed (result_o = 2) when the final total exceeds both the reported error count and 12. In that case count_o is the frozen total and fill_ones_o is 0.
- R7: Otherwise, after a scan, the result is erased (result_o = 1), count_o is 0 and fill_ones_o is 1.
- R8: A start_i pulse while a scan is in progress is ignored. It produces no done_o and does not change the limit used by that scan.
- R9: A word is taken only in a cycle where word_valid_i and word_ready_o are both high. Data presented while word_valid_i is low does not count.
- R10: result_o, count_o and fill_ones_o hold their values in every cycle in which done_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Strobe that presents a new ECC status byte |
| status_i | input | 8 | ECC status: bit 7 uncorrectable flag, bits 5:0 error count |
| word_valid_i | input | 1 | Data word valid |
| word_data_i | input | 32 | Page data word |
| word_ready_o | output | 1 | Block accepts a data word |
| done_o | output | 1 | Single-cycle decision pulse |
| result_o | output | 2 | 0 correctable, 1 erased, 2 failed |
| count_o | output | 7 | Corrected bits, or the frozen zero count on failure |
| fill_ones_o | output | 1 | Request to overwrite the step with 0xFF |

## Verification
The running total, the stop flag and the word index are internal, so a wrong value in any of them shows up only at the done pulse at the end of a scan. A stop that fires too late changes count_o on a failed page. A stop that never fires moves the fail/erase boundary near 12 zeros. A word index that is off by one moves the done pulse by a cycle or leaves word_ready_o high for one cycle too many. The sweeps therefore place zeros in the first word, in the middle word and in the last word, and send pages whose every word is all zeros. They cover limits that sit on both sides of 12 and of the actual zero count, so each of these faults shows at the very first done pulse it affects.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_ERASED = 2'd1,
        RES_FAIL   = 2'd2
    } res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/ecc_zero_count.sv
module ecc_zero_count #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = WORD_W / LANE_W,
    localparam int CW    = $clog2(LANE_W + 1),
    localparam int ZW    = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [ZW-1:0]     zeros_o
);

    logic [CW-1:0] lane_cnt [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CW-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int b = 0; b < LANE_W; b++) begin
                cnt = cnt + CW'(!word_i[g*LANE_W + b]);
            end
        end
        assign lane_cnt[g] = cnt;
    end

    always_comb begin
        zeros_o = '0;
        for (int l = 0; l < LANES; l++) begin
            zeros_o = zeros_o + ZW'(lane_cnt[l]);
        end
    end

endmodule

// File: rtl/ecc_zero_accum.sv
module ecc_zero_accum #(
    parameter int ZW         = 6,
    parameter int LIM_W      = 6,
    parameter int TOT_W      = 7,
    parameter int STEP_WORDS = 512,
    localparam int IDX_W     = $clog2(STEP_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [LIM_W-1:0] limit_i,
    input  logic             beat_i,
    input  logic [ZW-1:0]    zeros_i,
    output logic [TOT_W-1:0] total_next_o,
    output logic             stopped_next_o,
    output logic             last_o
);

    typedef struct packed {
        logic [TOT_W-1:0] total;
        logic             stopped;
        logic [IDX_W-1:0] idx;
    } acc_t;

    acc_t st_d, st_q;
    logic [TOT_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = st_q.total + TOT_W'(zeros_i);
        if (clear_i) begin
            st_d = '0;
        end else if (beat_i) begin
            st_d.idx = st_q.idx + 1'b1;
            if (!st_q.stopped) begin
                st_d.total   = sum;
                st_d.stopped = (sum > TOT_W'(limit_i));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total_next_o   = st_d.total;
    assign stopped_next_o = st_d.stopped;
    assign last_o         = (st_q.idx == IDX_W'(STEP_WORDS - 1));

    // R5
    frozen_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stopped && !clear_i) |=> $stable(st_q.total))
        else $error("total moved after stop");

    // R5
    below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stopped |-> (st_q.total <= TOT_W'(limit_i)))
        else $error("total above limit without stop");

    // R9
    idle_no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_i && !clear_i) |=> $stable(st_q.idx))
        else $error("word index moved without a beat");

endmodule

// File: rtl/ecc_erased_check.sv
module ecc_erased_check
    import ecc_scan_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int STEP_WORDS = 512,
    parameter int STRENGTH   = 24,
    parameter int LIM_W      = 6,
    parameter int STAT_W     = 8,
    parameter int FLAG_BIT   = 7,
    localparam int ZW        = $clog2(WORD_W + 1),
    localparam int TOT_W     = $clog2((1 << LIM_W) - 1 + WORD_W + 1),
    localparam int HALF      = STRENGTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic              done_o,
    output logic [1:0]        result_o,
    output logic [TOT_W-1:0]  count_o,
    output logic              fill_ones_o
);

    typedef struct packed {
        scan_state_e      state;
        logic [LIM_W-1:0] limit;
        logic             done;
        res_e             result;
        logic [TOT_W-1:0] count;
        logic             fill;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             beat;
    logic             clear;
    logic [ZW-1:0]    zeros;
    logic [TOT_W-1:0] total_next;
    logic             stopped_next;
    logic             last_word;
    logic [STAT_W-1:0] status_unused;

    assign status_unused = status_i;

    ecc_zero_count #(
        .WORD_W (WORD_W),
        .LANE_W (8)
    ) u_zeros (
        .word_i  (word_data_i),
        .zeros_o (zeros)
    );

    ecc_zero_accum #(
        .ZW         (ZW),
        .LIM_W      (LIM_W),
        .TOT_W      (TOT_W),
        .STEP_WORDS (STEP_WORDS)
    ) u_accum (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (clear),
        .limit_i        (ctl_q.limit),
        .beat_i         (beat),
        .zeros_i        (zeros),
        .total_next_o   (total_next),
        .stopped_next_o (stopped_next),
        .last_o         (last_word)
    );

    assign word_ready_o = (ctl_q.state == ST_SCAN);
    assign beat         = word_valid_i && word_ready_o;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        clear      = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (status_i[FLAG_BIT]) begin
                        ctl_d.state = ST_SCAN;
                        ctl_d.limit = status_i[LIM_W-1:0];
                        clear       = 1'b1;
                    end else begin
                        ctl_d.done   = 1'b1;
                        ctl_d.result = RES_OK;
                        ctl_d.count  = TOT_W'(status_i[LIM_W-1:0]);
                        ctl_d.fill   = 1'b0;
                    end
                end
            end
            ST_SCAN: begin
                if (beat && last_word) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                    if (stopped_next && (total_next > TOT_W'(HALF))) begin
                        ctl_d.result = RES_FAIL;
                        ctl_d.count  = total_next;
                        ctl_d.fill   = 1'b0;
                    end else begin
                        ctl_d.result = RES_ERASED;
                        ctl_d.count  = '0;
                        ctl_d.fill   = 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.state  <= ST_IDLE;
            ctl_q.result <= RES_OK;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_o      = ctl_q.done;
    assign result_o    = ctl_q.result;
    assign count_o     = ctl_q.count;
    assign fill_ones_o = ctl_q.fill;

    // R3
    ready_off_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !word_ready_o)
        else $error("ready high during done");

    // R6
    fail_over_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == RES_FAIL) |-> (count_o > TOT_W'(HALF)))
        else $error("failure reported at or below half strength");

    // R7
    erased_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ones_o |-> (result_o == RES_ERASED && count_o == '0))
        else $error("fill request without erased result");

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(count_o) && $stable(fill_ones_o)))
        else $error("result changed without done");

endmodule

// File: tb/sim_ecc_erased_check.sv
module sim_ecc_erased_check;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  status_i = '0;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_data_i = '0;
    logic        word_ready_o;
    logic        done_o;
    logic [1:0]  result_o;
    logic [6:0]  count_o;
    logic        fill_ones_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ecc_erased_check u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .status_i     (status_i),
        .word_valid_i (word_valid_i),
        .word_data_i  (word_data_i),
        .word_ready_o (word_ready_o),
        .done_o       (done_o),
        .result_o     (result_o),
        .count_o      (count_o),
        .fill_ones_o  (fill_ones_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] zmask(input int z);
        if (z >= 32) return 32'h0;
        return ~((32'h1 << z) - 32'h1);
    endfunction

    function automatic logic [31:0] gen_word(input int mode, input int i, input int p, input int z);
        logic [31:0] x;
        case (mode)
            0: return 32'hFFFF_FFFF;
            1: return (i == p) ? zmask(z) : 32'hFFFF_FFFF;
            2: return zmask(z);
            default: begin
                x = (i + 1) * 32'h9E37_79B1 ^ p;
                x = x ^ (x >> 15);
                x = x * 32'h85EB_CA6B;
                x = x ^ (x >> 13);
                return x | {x[15:0], x[31:16]};
            end
        endcase
    endfunction

    function automatic int zeros_of(input logic [31:0] w);
        int n = 0;
        for (int b = 0; b < 32; b++) if (!w[b]) n++;
        return n;
    endfunction

    task automatic run_scan(input int lim, input int mode, input int p, input int z,
                            input bit gap, input bit inject);
        int total = 0;
        bit stopped = 0;
        bit exp_fail;
        int exp_res, exp_cnt, exp_fill;
        logic [31:0] w;
        for (int i = 0; i < 512; i++) begin
            if (!stopped) begin
                total += zeros_of(gen_word(mode, i, p, z));
                if (total > lim) stopped = 1;
            end
        end
        exp_fail = stopped && (total > 12);
        exp_res  = exp_fail ? 2 : 1;
        exp_cnt  = exp_fail ? total : 0;
        exp_fill = exp_fail ? 0 : 1;

        @(negedge clk);
        start_i  = 1'b1;
        status_i = {2'b10, 6'(lim)};
        @(negedge clk);
        start_i = 1'b0;
        check(word_ready_o == 1'b1, "R3 ready after start", int'(word_ready_o), 1);
        for (int i = 0; i < 512; i++) begin
            if (gap && (i % 5 == 0)) begin
                word_valid_i = 1'b0;
                word_data_i  = 32'h0;   // R9: not counted
                start_i      = 1'b0;
                @(negedge clk);
            end
            if (i == 511) check(done_o == 1'b0, "R3 no early done", int'(done_o), 0);
            w = gen_word(mode, i, p, z);
            word_valid_i = 1'b1;
            word_data_i  = w;
            start_i  = (inject && i == 100);   // R8: ignored during scan
            status_i = (inject && i == 100) ? 8'h03 : {2'b10, 6'(lim)};
            @(negedge clk);
        end
        word_valid_i = 1'b0;
        start_i      = 1'b0;
        check(done_o == 1'b1, "R3 done after last word", int'(done_o), 1);
        check(word_ready_o == 1'b0, "R3 ready low at done", int'(word_ready_o), 0);
        check(int'(result_o) == exp_res, exp_fail ? "R6 result" : "R7 result", int'(result_o), exp_res);
        check(int'(count_o) == exp_cnt, exp_fail ? "R6 count R5 R4" : "R7 count", int'(count_o), exp_cnt);
        check(int'(fill_ones_o) == exp_fill, exp_fail ? "R6 fill" : "R7 fill", int'(fill_ones_o), exp_fill);
        @(negedge clk);
        check(done_o == 1'b0, "R10 done single cycle", int'(done_o), 0);
        check(int'(count_o) == exp_cnt && int'(result_o) == exp_res,
              "R10 held", int'(count_o), exp_cnt);
        if (inject) check(done_o == 1'b0 && int'(result_o) == exp_res, "R8 start ignored",
                          int'(result_o), exp_res);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lims [7] = '{0, 1, 11, 12, 13, 40, 63};
        int k;
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check(done_o == 0 && word_ready_o == 0, "R1 in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 0 && word_ready_o == 0 && result_o == 0 && count_o == 0 && fill_ones_o == 0,
              "R1 after reset", int'(count_o), 0);

        // R2: correctable sweep over every count, bit 6 toggled
        for (int c = 0; c < 128; c++) begin
            start_i  = 1'b1;
            status_i = {1'b0, 1'(c >> 6), 6'(c)};
            @(negedge clk);
            start_i = 1'b0;
            check(done_o == 1'b1, "R2 done", int'(done_o), 1);
            check(int'(result_o) == 0 && fill_ones_o == 1'b0, "R2 result", int'(result_o), 0);
            check(int'(count_o) == (c % 64), "R2 count", int'(count_o), c % 64);
            check(word_ready_o == 1'b0, "R2 no words", int'(word_ready_o), 0);
            @(negedge clk);
            check(done_o == 1'b0 && int'(count_o) == (c % 64), "R10 hold after R2",
                  int'(count_o), c % 64);
        end

        // R4 R5 R6 R7 R9: scan sweep
        k = 0;
        for (int li = 0; li < 7; li++) begin
            for (int cs = 0; cs < 7; cs++) begin
                case (cs)
                    0: run_scan(lims[li], 0, 0,   0,  (k % 3) == 0, (k % 4) == 1);
                    1: run_scan(lims[li], 1, 200, 13, (k % 3) == 0, (k % 4) == 1);
                    2: run_scan(lims[li], 1, 511, 32, (k % 3) == 0, (k % 4) == 1);
                    3: run_scan(lims[li], 1, 0,   1,  (k % 3) == 0, (k % 4) == 1);
                    4: run_scan(lims[li], 2, 0,   1,  (k % 3) == 0, (k % 4) == 1);
                    5: run_scan(lims[li], 2, 0,   32, (k % 3) == 0, (k % 4) == 1);
                    default: run_scan(lims[li], 3, k, 0, (k % 3) == 0, (k % 4) == 1);
                endcase
                k++;
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule